// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous request source and an external asynchronous static RAM of 128K 16-bit words. It accepts one write at a time through a valid/ready handshake that carries a word address, a data word and one enable per byte lane. It then runs a complete write cycle on the memory pins: address bus, an active-low and an active-high chip select, an active-low write strobe, one active-low strobe per byte lane, the outgoing data word and the enable for the data pad's tri-state driver.

The memory stores data only while both chip selects, the write strobe and at least one lane strobe are active at once. The cycle ends at the first of these to drop, and data setup and hold count from that edge. The sequencer therefore sets up the selects, lane strobes and address in the same cycle the write strobe falls. It keeps them steady while the strobe is low and releases them only after the strobe has risen, so the write strobe's rising edge is always the edge that ends the write. The data driver waits out the memory's output turn-off delay before it drives the bus, and it lets go in the cycle the strobe rises.

Every minimum time is a parameter in picoseconds. Each is turned into a cycle count by dividing by the clock period and rounding up. The low time of the write strobe is the largest of the strobe width, address-to-end, select-to-end, lane-to-end, and turn-off delay plus data setup. The release phase stretches the cycle to at least the minimum write-cycle time.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held and whenever no write is in progress: mem_cs_n=1, mem_cs=0, mem_wr_n=1, every mem_lane_n bit 1, mem_dq_oe=0 and req_ready=1.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. In the cycle after that edge, mem_wr_n is 0 and both chip selects are active.
- R3: Lane strobes are active-low copies of the captured lane enables, with bit 1 the upper byte and bit 0 the lower byte. A request with both enables 0 still runs a full cycle, with both lane strobes held at 1.
- R4: mem_wr_n stays low for exactly N_LOW cycles, where N_LOW is the largest of ceil(T_PWE), ceil(T_AW), ceil(T_SCE), ceil(T_PWB) and ceil(T_HZ)+ceil(T_SD), each time divided by the clock period.
- R5: While mem_wr_n is low, mem_addr equals the captured address and the chip selects and lane strobes do not change.
- R6: Counting the first low cycle of mem_wr_n as cycle 0, mem_dq_oe is 1 from cycle ceil(T_HZ) through the last low cycle and 0 before that. While it is 1, mem_dout equals the captured data word.
- R7: mem_dq_oe is 0 in the cycle mem_wr_n rises and in every cycle mem_wr_n is high.
- R8: After mem_wr_n rises, the chip selects, lane strobes and address stay as they were for N_REC = max(1, ceil(T_WC) - N_LOW) cycles. After that the block returns to the R1 state.
- R9: req_ready is 0 from the accepting edge until the return to the idle state. Requests presented during that time, and changes to the request inputs after acceptance, do not affect the running cycle. A request held valid is taken as soon as req_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 17 | Word address |
| req_data | input | 16 | Data word |
| req_be | input | 2 | Byte-lane enables, bit 1 upper, active high |
| mem_addr | output | 17 | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_lane_n | output | 2 | Active-low byte-lane strobes, bit 1 upper |
| mem_dout | output | 16 | Data to the memory's data pins |
| mem_dq_oe | output | 1 | Enable for the tri-state data driver |

## Verification
The bench builds the block with a 4 ns clock and the slowest speed grade's times. This gives a 20-cycle strobe in which turn-off delay plus setup exactly ties the strobe-width limits, and a 5-cycle release phase, so the release counter runs past one cycle. With these values the bench sweeps all four lane-enable combinations over a walking-one address and an all-ones address, with varied data, and checks every pin in every cycle of every write. It also holds a second request valid through a running cycle, to show the request is ignored and then taken as soon as ready returns.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STROBE  = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    // Minimum time in picoseconds to whole clock cycles, rounded up.
    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_phase.sv
module sram_wr_phase
    import sram_wr_pkg::*;
#(
    parameter int N_LOW = 20,
    parameter int N_REC = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_e           phase_d,
    output phase_e           phase_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic             idle
);

    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(N_LOW - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(N_REC - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                seq_d.cnt = '0;
                if (start) begin
                    seq_d.ph = PH_STROBE;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == LOW_LAST) begin
                    seq_d.ph  = PH_RELEASE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_RELEASE: begin
                if (seq_q.cnt == REC_LAST) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.ph  = PH_IDLE;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_d = seq_d.ph;
    assign phase_q = seq_q.ph;
    assign cnt_d   = seq_d.cnt;
    assign cnt_q   = seq_q.cnt;
    assign idle    = (seq_q.ph == PH_IDLE);

endmodule

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANES-1:0]  be_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [LANES-1:0]  be_d,
    output logic [LANES-1:0]  be_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.addr = addr_i;
            cap_d.data = data_i;
            cap_d.be   = be_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_q = cap_q.addr;
    assign data_q = cap_q.data;
    assign be_d   = cap_d.be;
    assign be_q   = cap_q.be;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int LANES = 2,
    parameter int CNT_W = 5,
    parameter int N_HZ  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase_d,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [LANES-1:0] be_d,
    output logic             cs_n,
    output logic             cs,
    output logic             wr_n,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] HZ_CNT = CNT_W'(N_HZ);

    typedef struct packed {
        logic             cs_n;
        logic             cs;
        logic             wr_n;
        logic [LANES-1:0] lane_n;
        logic             dq_oe;
    } pin_t;

    pin_t pin_d, pin_q;
    logic             busy_d;
    logic [LANES-1:0] lane_n_d;

    assign busy_d = (phase_d != PH_IDLE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n_d[g] = !(busy_d && be_d[g]);
    end

    always_comb begin
        pin_d        = pin_q;
        pin_d.cs_n   = !busy_d;
        pin_d.cs     = busy_d;
        pin_d.wr_n   = (phase_d != PH_STROBE);
        pin_d.lane_n = lane_n_d;
        pin_d.dq_oe  = (phase_d == PH_STROBE) && (cnt_d >= HZ_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '{cs_n: 1'b1, cs: 1'b0, wr_n: 1'b1,
                       lane_n: '1, dq_oe: 1'b0};
        end else begin
            pin_q <= pin_d;
        end
    end

    assign cs_n   = pin_q.cs_n;
    assign cs     = pin_q.cs;
    assign wr_n   = pin_q.wr_n;
    assign lane_n = pin_q.lane_n;
    assign dq_oe  = pin_q.dq_oe;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 16,
    parameter int CLK_PS   = 4000,
    parameter int T_WC_PS  = 55000,
    parameter int T_SCE_PS = 50000,
    parameter int T_AW_PS  = 50000,
    parameter int T_PWB_PS = 45000,
    parameter int T_PWE_PS = 45000,
    parameter int T_SD_PS  = 25000,
    parameter int T_HZ_PS  = 30000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [DATA_W/8-1:0] req_be,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_cs,
    output logic                mem_wr_n,
    output logic [DATA_W/8-1:0] mem_lane_n,
    output logic [DATA_W-1:0]   mem_dout,
    output logic                mem_dq_oe
);

    localparam int LANES = DATA_W / 8;
    localparam int N_WC  = ps_to_cycles(T_WC_PS,  CLK_PS);
    localparam int N_SCE = ps_to_cycles(T_SCE_PS, CLK_PS);
    localparam int N_AW  = ps_to_cycles(T_AW_PS,  CLK_PS);
    localparam int N_PWB = ps_to_cycles(T_PWB_PS, CLK_PS);
    localparam int N_PWE = ps_to_cycles(T_PWE_PS, CLK_PS);
    localparam int N_SD  = ps_to_cycles(T_SD_PS,  CLK_PS);
    localparam int N_HZ  = ps_to_cycles(T_HZ_PS,  CLK_PS);
    localparam int N_LOW = imax(imax(imax(N_PWE, N_AW), imax(N_SCE, N_PWB)),
                                imax(N_HZ + N_SD, 1));
    localparam int N_REC = imax(1, N_WC - N_LOW);
    localparam int CNT_W = $clog2(imax(N_LOW, N_REC) + 1);

    phase_e           phase_d, phase_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             idle;
    logic             start;
    logic [LANES-1:0] be_d, be_q;

    assign req_ready = idle;
    assign start     = req_valid && idle;

    sram_wr_phase #(
        .N_LOW (N_LOW),
        .N_REC (N_REC),
        .CNT_W (CNT_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .phase_d (phase_d),
        .phase_q (phase_q),
        .cnt_d   (cnt_d),
        .cnt_q   (cnt_q),
        .idle    (idle)
    );

    sram_wr_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .addr_i (req_addr),
        .data_i (req_data),
        .be_i   (req_be),
        .addr_q (mem_addr),
        .data_q (mem_dout),
        .be_d   (be_d),
        .be_q   (be_q)
    );

    sram_wr_pins #(
        .LANES (LANES),
        .CNT_W (CNT_W),
        .N_HZ  (N_HZ)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .cnt_d   (cnt_d),
        .be_d    (be_d),
        .cs_n    (mem_cs_n),
        .cs      (mem_cs),
        .wr_n    (mem_wr_n),
        .lane_n  (mem_lane_n),
        .dq_oe   (mem_dq_oe)
    );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int LANES  = 2,
    parameter int N_LOW  = 20,
    parameter int N_REC  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_wr_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic              mem_dq_oe
);

    int low_run;
    int rel_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
            rel_run <= 0;
        end else begin
            low_run <= mem_wr_n ? 0 : low_run + 1;
            rel_run <= (!mem_cs_n && mem_wr_n) ? rel_run + 1 : 0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_wr_n && (&mem_lane_n) && !mem_dq_oe));

    assert_select_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> (!mem_cs_n && mem_cs && !req_ready));

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (low_run == N_LOW));

    assert_window_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |->
            ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_cs) && $stable(mem_lane_n)));

    assert_driver_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(!mem_wr_n));

    assert_driver_off_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_n |-> !mem_dq_oe);

    assert_hold_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (!mem_cs_n && mem_cs));

    assert_release_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> (rel_run == N_REC));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .N_LOW  (N_LOW),
    .N_REC  (N_REC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_wr_n   (mem_wr_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;

    localparam int CLK_PS = 4000;
    localparam int T_WC   = 100000;
    localparam int T_SCE  = 80000;
    localparam int T_AW   = 80000;
    localparam int T_PWB  = 80000;
    localparam int T_PWE  = 80000;
    localparam int T_SD   = 40000;
    localparam int T_HZ   = 40000;

    function automatic int cyc(input int t);
        return (t + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_HZ  = cyc(T_HZ);
    localparam int E_LOW = mx(mx(mx(cyc(T_PWE), cyc(T_AW)), mx(cyc(T_SCE), cyc(T_PWB))),
                              E_HZ + cyc(T_SD));
    localparam int E_REC = mx(1, cyc(T_WC) - E_LOW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_be = '0;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_wr_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_wr_seq #(
        .ADDR_W(17), .DATA_W(16), .CLK_PS(CLK_PS),
        .T_WC_PS(T_WC), .T_SCE_PS(T_SCE), .T_AW_PS(T_AW), .T_PWB_PS(T_PWB),
        .T_PWE_PS(T_PWE), .T_SD_PS(T_SD), .T_HZ_PS(T_HZ)
    ) u_sram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_wr_n(mem_wr_n), .mem_lane_n(mem_lane_n), .mem_dout(mem_dout),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(mem_cs_n == 1'b1 && mem_cs == 1'b0, req, "selects idle", {mem_cs_n, mem_cs}, 32'h2);
        chk(mem_wr_n == 1'b1, req, "write strobe idle", 32'(mem_wr_n), 32'h1);
        chk(mem_lane_n == 2'b11, req, "lane strobes idle", 32'(mem_lane_n), 32'h3);
        chk(mem_dq_oe == 1'b0, req, "driver idle", 32'(mem_dq_oe), 32'h0);
        chk(req_ready == 1'b1, req, "ready idle", 32'(req_ready), 32'h1);
    endtask

    // Called at the falling edge right after the accepting rising edge.
    task automatic mon(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        for (int k = 0; k <= E_LOW + E_REC; k++) begin
            if (k < E_LOW) begin
                chk(mem_wr_n == 1'b0, (k == 0) ? "R2" : "R4", "strobe low",
                    32'(mem_wr_n), 32'h0);
                chk(mem_cs_n == 1'b0 && mem_cs == 1'b1, (k == 0) ? "R2" : "R5",
                    "selects active", {mem_cs_n, mem_cs}, 32'h1);
                chk(mem_lane_n == ~be, "R3", "lane strobes", 32'(mem_lane_n), 32'(~be));
                chk(mem_addr == a, "R5", "address", 32'(mem_addr), 32'(a));
                chk(mem_dq_oe == (k >= E_HZ), "R6", "driver enable",
                    32'(mem_dq_oe), 32'(k >= E_HZ));
                if (k >= E_HZ) begin
                    chk(mem_dout == d, "R6", "data", 32'(mem_dout), 32'(d));
                end
                chk(req_ready == 1'b0, "R9", "ready busy", 32'(req_ready), 32'h0);
            end else if (k < E_LOW + E_REC) begin
                chk(mem_wr_n == 1'b1, "R4", "strobe high", 32'(mem_wr_n), 32'h1);
                chk(mem_dq_oe == 1'b0, "R7", "driver off", 32'(mem_dq_oe), 32'h0);
                chk(mem_cs_n == 1'b0 && mem_cs == 1'b1, "R8", "selects held",
                    {mem_cs_n, mem_cs}, 32'h1);
                chk(mem_lane_n == ~be, "R8", "lanes held", 32'(mem_lane_n), 32'(~be));
                chk(mem_addr == a, "R8", "address held", 32'(mem_addr), 32'(a));
                chk(req_ready == 1'b0, "R9", "ready busy", 32'(req_ready), 32'h0);
            end else begin
                chk_idle("R8");
            end
            if (k < E_LOW + E_REC) @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_data  = ~d;
        req_be    = ~be;
        mon(a, d, be);
    endtask

    task automatic do_held(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                           input logic [16:0] a2, input logic [15:0] d2, input logic [1:0] be2);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        req_be    = be;
        @(negedge clk);
        req_addr  = a2;
        req_data  = d2;
        req_be    = be2;
        mon(a, d, be);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = '0;
        mon(a2, d2, be2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 18; i++) begin
                logic [16:0] a;
                logic [15:0] d;
                a = (i == 17) ? 17'h1FFFF : 17'(1 << i);
                d = 16'(16'hA5C3 ^ (i * 16'h0F13) ^ (b << 12));
                do_write(a, d, 2'(b));
            end
        end
        do_held(17'h0ACE5, 16'h1234, 2'b01, 17'h15A3C, 16'hFEDC, 2'b10);
        do_held(17'h00000, 16'hFFFF, 2'b11, 17'h1FFFF, 16'h0000, 2'b00);
        repeat (2) @(negedge clk);
        chk_idle("R1");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                #(4 * 150000);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule